// File: doc/BRIEF.md
# Programmable Event Timer

A down-counting event timer with a 56-bit count, programmed over a simple 32-bit register bus. Software first stores the low 32 bits of a reload value. It then writes one control word that carries the remaining 24 count bits, a run enable, a repeat selector and a self-clearing load strobe. The control write, and only the control write, copies the full reload value into the live counter.

While the timer runs, the count falls by one on every clock. When it reaches its last step, the timer signals an expiry. In one-shot mode the timer then parks at zero with its enable cleared. In repeat mode it refills itself from the stored reload value and keeps going, so it expires every N clocks for a programmed count of N.

Each expiry latches a pending flag. The interrupt line is that flag gated by an enable bit. Separate set and clear addresses change the enable bit, so no read-modify-write is needed. A write-one-to-clear address acknowledges the pending flag. If an acknowledge and a fresh expiry land on the same clock, the expiry is kept.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, both reload fields, the enable and repeat flags, the interrupt enable and the pending flag are all zero, every readable address returns zero, and `irqOut` is low.
- R2: A write to byte address 0x000 stores the low 32 reload bits, which read back at 0x000. It does not change the live count or the run state.
- R3: A write to 0x004 stores bits 23:0 as reload bits 55:32, bit 24 as enable and bit 28 as repeat. If bit 30 (load) is 1, the count becomes {bits 23:0, stored low word} on that clock. A read of 0x004 returns the high reload bits, enable and repeat at those same positions, and bit 30 always reads 0.
- R4: While enabled, the count drops by one on each clock. Its low 32 bits read at 0x008, and bits 55:32 read as bits 23:0 at 0x00C.
- R5: With count N (N ≥ 1) loaded by a control write, the expiry occurs on the Nth clock after that write. The pending flag (bit 0 at 0x034) is set from the clock after the expiry onward.
- R6: With repeat 0, an expiry leaves the count at zero and the enable reading 0, and no further expiry follows.
- R7: With repeat 1, an expiry reloads the stored 56-bit value, leaves the enable at 1, and the next expiry follows N clocks later.
- R8: A control write of zero stops the timer, and the count then holds its value.
- R9: Writing bit 0 = 1 at 0x02C sets the interrupt enable, and writing bit 0 = 1 at 0x030 clears it. A write with bit 0 = 0 to either address leaves it unchanged. The enable reads back as bit 0 at 0x02C.
- R10: `irqOut` is high exactly when both the pending flag and the interrupt enable are set.
- R11: Writing bit 0 = 1 at 0x034 clears the pending flag, and a write with bit 0 = 0 leaves it set. An expiry on the same clock as a clearing write leaves the flag set.
- R12: A control write with load 0 updates the high reload bits and the flags but keeps the live count. A run enabled this way resumes from that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| busWrite | input | 1 | Write strobe for one clock |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irqOut | output | 1 | Pending flag gated by the interrupt enable |

## Verification
The assertions assume that each write is a single-clock pulse with a stable address and data. They also assume that software does not write the low word and the control word in the same clock, which the single address makes impossible anyway. The stimulus drives every bus transfer half a cycle away from the active edge and programs counts of at least 2 whenever it sweeps periods, as the software contract expects. It times acknowledges to hit chosen clocks exactly, including the expiry clock itself, so that the same-clock rule is exercised deliberately rather than by chance.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // byte offsets of the register window
  localparam int unsigned OFF_RELOAD_LO = 'h000;
  localparam int unsigned OFF_CTRL      = 'h004;
  localparam int unsigned OFF_COUNT_LO  = 'h008;
  localparam int unsigned OFF_COUNT_HI  = 'h00C;
  localparam int unsigned OFF_MASK_SET  = 'h02C;
  localparam int unsigned OFF_MASK_CLR  = 'h030;
  localparam int unsigned OFF_ACK       = 'h034;

  // control word bit positions
  localparam int unsigned EN_BIT   = 24;
  localparam int unsigned REP_BIT  = 28;
  localparam int unsigned LOAD_BIT = 30;

  // decoded write strobes from control to datapath
  typedef struct packed {
    logic wrLow;
    logic wrCtrl;
    logic maskSet;
    logic maskClr;
    logic ack;
  } evtStrobe_t;

endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] reloadLow,
  input  logic [CNT_W-DATA_W-1:0] ctrlHigh,
  input  logic              runFlag,
  input  logic              repFlag,
  input  logic [CNT_W-1:0]  countVal,
  output evtStrobe_t        strobe,
  output logic              pending,
  output logic              maskEn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  localparam int HIGH_W = CNT_W - DATA_W;

  // address decode into strobes
  always_comb begin
    strobe = '0;
    if (busWrite) begin
      strobe.wrLow   = (busAddr == ADDR_W'(OFF_RELOAD_LO));
      strobe.wrCtrl  = (busAddr == ADDR_W'(OFF_CTRL));
      strobe.maskSet = (busAddr == ADDR_W'(OFF_MASK_SET)) && busWdata[0];
      strobe.maskClr = (busAddr == ADDR_W'(OFF_MASK_CLR)) && busWdata[0];
      strobe.ack     = (busAddr == ADDR_W'(OFF_ACK)) && busWdata[0];
    end
  end

  // interrupt enable with separate set and clear addresses
  always_ff @(posedge clk) begin
    if (!rstN) maskEn <= 1'b0;
    else if (strobe.maskSet) maskEn <= 1'b1;
    else if (strobe.maskClr) maskEn <= 1'b0;
  end

  // pending flag: a new expiry outranks an acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (strobe.ack) pending <= 1'b0;
  end

  assign irqOut = pending & maskEn;

  // read mux
  logic [DATA_W-1:0] ctrlWord;
  always_comb begin
    ctrlWord = '0;
    ctrlWord[HIGH_W-1:0] = ctrlHigh;
    ctrlWord[EN_BIT]     = runFlag;
    ctrlWord[REP_BIT]    = repFlag;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFF_RELOAD_LO): busRdata = reloadLow;
      ADDR_W'(OFF_CTRL):      busRdata = ctrlWord;
      ADDR_W'(OFF_COUNT_LO):  busRdata = countVal[DATA_W-1:0];
      ADDR_W'(OFF_COUNT_HI):  busRdata = {{(DATA_W-HIGH_W){1'b0}}, countVal[CNT_W-1:DATA_W]};
      ADDR_W'(OFF_MASK_SET):  busRdata = {{(DATA_W-1){1'b0}}, maskEn};
      ADDR_W'(OFF_ACK):       busRdata = {{(DATA_W-1){1'b0}}, pending};
      default:                busRdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] reloadLow,
  output logic [CNT_W-DATA_W-1:0] ctrlHigh,
  output logic              runFlag,
  output logic              repFlag,
  output logic [CNT_W-1:0]  countVal,
  output logic              expire
);

  localparam int HIGH_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] loadVal;

  assign reloadVal = {ctrlHigh, reloadLow};
  assign loadVal   = {busWdata[HIGH_W-1:0], reloadLow};

  // last step of a running count; a control write in the same clock takes over
  assign expire = runFlag && (countVal <= CNT_W'(1)) && !strobe.wrCtrl;

  always_ff @(posedge clk) begin
    if (!rstN) reloadLow <= '0;
    else if (strobe.wrLow) reloadLow <= busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlHigh <= '0;
      runFlag  <= 1'b0;
      repFlag  <= 1'b0;
      countVal <= '0;
    end else if (strobe.wrCtrl) begin
      ctrlHigh <= busWdata[HIGH_W-1:0];
      runFlag  <= busWdata[EN_BIT];
      repFlag  <= busWdata[REP_BIT];
      if (busWdata[LOAD_BIT]) countVal <= loadVal;
    end else if (expire) begin
      if (repFlag) begin
        countVal <= reloadVal;
      end else begin
        countVal <= '0;
        runFlag  <= 1'b0;
      end
    end else if (runFlag) begin
      countVal <= countVal - CNT_W'(1);
    end
  end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  localparam int HIGH_W = CNT_W - DATA_W;

  evtStrobe_t        strobe;
  logic              expire;
  logic              pending;
  logic              maskEn;
  logic              runFlag;
  logic              repFlag;
  logic [DATA_W-1:0] reloadLow;
  logic [HIGH_W-1:0] ctrlHigh;
  logic [CNT_W-1:0]  countVal;

  evt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .expire(expire), .reloadLow(reloadLow),
    .ctrlHigh(ctrlHigh), .runFlag(runFlag), .repFlag(repFlag),
    .countVal(countVal), .strobe(strobe), .pending(pending),
    .maskEn(maskEn), .busRdata(busRdata), .irqOut(irqOut)
  );

  evt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .reloadLow(reloadLow), .ctrlHigh(ctrlHigh), .runFlag(runFlag),
    .repFlag(repFlag), .countVal(countVal), .expire(expire)
  );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 56
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              expire,
  input logic              pending,
  input logic              maskEn,
  input logic              runFlag,
  input logic              repFlag,
  input logic [DATA_W-1:0] reloadLow,
  input logic [CNT_W-DATA_W-1:0] ctrlHigh,
  input logic [CNT_W-1:0]  countVal,
  input logic              irqOut
);

  localparam int HIGH_W = CNT_W - DATA_W;

  logic hitCtrl;
  assign hitCtrl = busWrite && (busAddr == ADDR_W'(OFF_CTRL));

  p_low_no_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(OFF_RELOAD_LO) && !runFlag)
      |=> $stable(countVal) && !runFlag);

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hitCtrl && busWdata[LOAD_BIT])
      |=> countVal == {$past(busWdata[HIGH_W-1:0]), $past(reloadLow)});

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && countVal > CNT_W'(1) && !hitCtrl)
      |=> countVal == $past(countVal) - CNT_W'(1));

  p_expiry_pends_r5: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> pending);

  p_oneshot_parks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !repFlag) |=> (!runFlag && countVal == '0));

  p_periodic_refill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (expire && repFlag) |=> (runFlag && countVal == $past({ctrlHigh, reloadLow})));

  p_zero_stops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hitCtrl && busWdata == '0) |=> (!runFlag && $stable(countVal)));

  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(OFF_MASK_SET) && busWdata[0]) |=> maskEn);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pending && maskEn));

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(OFF_ACK) && busWdata[0] && !expire) |=> !pending);

endmodule

bind evt_timer evt_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_evt_timer.sv
`timescale 1ns/10ps
module sim_evt_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evt_timer u0 (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #0.2;
    check(tag, busRdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [55:0] val, input logic rep);
    wr(8'h00, val[31:0]);
    wr(8'h04, {24'h0, 8'h0} | 32'(val[55:32]) | (32'h1 << 24) | (32'h1 << 30) | (32'(rep) << 28));
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    checkReg("R1 reload", 8'h00, 0);
    checkReg("R1 ctrl", 8'h04, 0);
    checkReg("R1 count", 8'h08, 0);
    checkReg("R1 pending", 8'h34, 0);
    idle(1);
    checkReg("R1 mask", 8'h2C, 0);
    check("R1 irq", 32'(irqOut), 0);

    // R5/R6 one-shot sweep
    for (int n = 2; n <= 20; n++) begin
      arm(56'(n), 1'b0);
      checkReg("R3 load count", 8'h08, n);
      idle(n - 1);
      checkReg("R5 not yet", 8'h34, 0);
      checkReg("R4 count one", 8'h08, 1);
      idle(1);
      checkReg("R5 pending", 8'h34, 1);
      checkReg("R6 count zero", 8'h08, 0);
      checkReg("R6 enable off", 8'h04, 0);
      wr(8'h34, 1);
      idle(2 * n);
      checkReg("R6 no rerun", 8'h34, 0);
    end

    // R7 periodic sweep, then R8 stop
    for (int n = 2; n <= 12; n++) begin
      arm(56'(n), 1'b1);
      idle(n);
      checkReg("R7 first", 8'h34, 1);
      wr(8'h34, 1);
      checkReg("R11 cleared", 8'h34, 0);
      checkReg("R7 reloaded", 8'h08, n - 1);
      idle(n - 2);
      checkReg("R7 gap", 8'h34, 0);
      idle(1);
      checkReg("R7 second", 8'h34, 1);
      checkReg("R7 enable kept", 8'h04, (32'h1 << 24) | (32'h1 << 28));
      wr(8'h04, 0);
      checkReg("R8 held", 8'h08, n);
      idle(5);
      checkReg("R8 still", 8'h08, n);
      wr(8'h34, 1);
    end

    // R11 acknowledge on the expiry clock
    arm(56'd6, 1'b0);
    idle(5);
    wr(8'h34, 1);
    checkReg("R11 expiry wins", 8'h34, 1);

    // R9/R10 mask with pending set
    check("R10 masked", 32'(irqOut), 0);
    wr(8'h2C, 0);
    checkReg("R9 zero set", 8'h2C, 0);
    check("R10 still low", 32'(irqOut), 0);
    wr(8'h2C, 1);
    checkReg("R9 set", 8'h2C, 1);
    check("R10 high", 32'(irqOut), 1);
    wr(8'h30, 0);
    checkReg("R9 zero clr", 8'h2C, 1);
    wr(8'h30, 1);
    checkReg("R9 clr", 8'h2C, 0);
    check("R10 low again", 32'(irqOut), 0);
    wr(8'h2C, 1);
    wr(8'h34, 0);
    checkReg("R11 zero ack", 8'h34, 1);
    check("R10 with mask", 32'(irqOut), 1);
    wr(8'h34, 1);
    checkReg("R11 ack", 8'h34, 0);
    check("R10 after ack", 32'(irqOut), 0);

    // R2, R8, R12
    arm(56'd40, 1'b0);
    idle(3);
    wr(8'h04, 0);
    checkReg("R8 stop value", 8'h08, 37);
    wr(8'h00, 32'hDEADBEEF);
    checkReg("R2 reload", 8'h00, 32'hDEADBEEF);
    checkReg("R2 count kept", 8'h08, 37);
    checkReg("R2 idle", 8'h04, 0);
    wr(8'h04, 32'h1 << 24);
    checkReg("R12 kept", 8'h08, 37);
    idle(1);
    checkReg("R12 resumed", 8'h08, 36);
    wr(8'h04, 0);

    // R3/R4 full-width value
    arm(56'h123456_89ABCDEF, 1'b1);
    checkReg("R3 ctrl read", 8'h04, 32'h11123456);
    checkReg("R3 count lo", 8'h08, 32'h89ABCDEF);
    checkReg("R3 count hi", 8'h0C, 32'h00123456);
    idle(1);
    checkReg("R4 dec", 8'h08, 32'h89ABCDEE);
    wr(8'h04, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule